// File: doc/BRIEF.md
# Multi-device serial channel controller

This block runs one channel of a synchronous serial link that is shared by up to three attached devices. Software programs it through five word registers. A select register drives a one-hot chip-select and picks a serial clock rate. A control register starts a transfer and reports completion. A left-aligned data register holds immediate transfers. An address register and a length register feed DMA reads. Immediate transfers move 1, 2 or 4 bytes, most significant bit first, in one of three directions: write only, read only, or full duplex.

A DMA read shifts in a multiple of 32 bytes from the selected device. It packs the bytes big-endian into 32-bit words and writes each group of 32 bytes to memory as one burst over a single-beat-acknowledge master port. The start bit reads back as one while any transfer is in flight and clears by itself, so software polls it. Chip-select stays asserted between transfers until software writes the select field again. A typical probe selects a device, writes the 2-byte command 0x0000 and then reads 4 bytes. A device that is not present returns 0xFFFFFFFF.

Register word indices: 0 select, 1 control, 2 data, 3 DMA address, 4 DMA length.

Top module: `sio_chan_ctrl`

## Requirements
- R1: After reset every register reads zero, chip-select is all zero, the serial clock and data-out are low, and no DMA request is raised.
- R2: Select register bits [2:0] drive the chip-select pins directly when at most one bit is set. A value with more than one bit set, or zero, deselects every device. Chip-select stays unchanged across transfers.
- R3: Writing control with bit 0 set starts a transfer. Control bit 0 reads one from the next cycle until the transfer ends, then clears by itself.
- R4: Control bits [3:2] select direction: 1 is write only. In that mode data register bytes go out from bit 31 downward, for (bits [5:4] + 1) bytes, one byte per 8 clocks, MSB first, and the data register is left unchanged.
- R5: Direction 0 is read only: the line sends 0xFF bytes, and received bytes replace data register bytes from bit 31 downward, leaving lower unused bytes unchanged. An absent device yields all ones.
- R6: Direction 2 (or 3) is full duplex: each byte sent from the data register is replaced by the byte received at the same time.
- R7: The serial clock idles low. Each half period lasts DIV_BASE << rate clocks, where rate is select bits [9:8]. Input data is sampled on the rising edge, and output data changes after the falling edge.
- R8: Control bit 1 with start and direction 0 runs a DMA read of the length register's byte count. Bytes are packed big-endian. Each 8-word burst goes to consecutive word addresses from the address register, and the final beat is flagged. A request holds steady until acknowledged, and start clears only after the last burst beat is acknowledged.
- R9: Register writes while start reads one are ignored, whether they target select, data, address, length or control.
- R10: The address and length registers ignore their low 5 bits and read them back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cs | output | NDEV | One-hot device select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| dma_req | output | 1 | Memory write beat valid |
| dma_addr | output | AW | Beat byte address |
| dma_wdata | output | 32 | Beat data |
| dma_last | output | 1 | Final beat of a burst |
| dma_ack | input | 1 | Beat accepted |

## Verification
The bench builds the block with DIV_BASE set to 2, so rate 0 gives a 4-clock serial period and rate 2 a 16-clock period. This keeps a 64-byte DMA read, and with it two full bursts and a burst boundary, short enough to run. The default burst of 8 words and three devices are kept, so a present device on select 0 and absent devices on 1 and 2 cover both the normal and the all-ones read. The acknowledge alternates with idle cycles so that stalled beats are exercised.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [2:0] REG_SEL  = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_DATA = 3'd2;
  localparam logic [2:0] REG_ADDR = 3'd3;
  localparam logic [2:0] REG_LEN  = 3'd4;

  localparam int CTRL_START = 0;
  localparam int CTRL_DMA   = 1;
  localparam int CTRL_DIR   = 2;
  localparam int CTRL_LEN   = 4;
  localparam int SEL_RATE   = 8;

  localparam logic [1:0] DIR_RD = 2'd0;
  localparam logic [1:0] DIR_WR = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_NEXT, ST_RUN, ST_DRAIN} sio_st_e;

  // byte idx of a left-aligned word: idx 0 sits at bits 31:24
  function automatic logic [7:0] imm_byte(input logic [31:0] w, input logic [1:0] idx);
    return w[(5'd24 - {idx, 3'b000}) +: 8];
  endfunction

  function automatic logic [31:0] imm_merge(input logic [31:0] w, input logic [1:0] idx,
                                            input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[(5'd24 - {idx, 3'b000}) +: 8] = b;
    return r;
  endfunction

  function automatic int unsigned half_cycles(input int unsigned base, input int unsigned rate);
    return base << rate;
  endfunction

  function automatic int ones_in(input logic [7:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/sio_shift.sv
module sio_shift #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       tx,
  input  logic [CNT_W-1:0] half,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx
);
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       tsr_q;
  logic [7:0]       rsr_q;
  logic [2:0]       nbit_q;
  logic             sclk_q;
  logic             done_q;
  logic             edge_due;

  assign edge_due = act_q && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      tsr_q  <= '0;
      rsr_q  <= '0;
      nbit_q <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        act_q  <= 1'b1;
        cnt_q  <= '0;
        tsr_q  <= tx;
        nbit_q <= '0;
        sclk_q <= 1'b0;
      end else if (edge_due) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rsr_q  <= {rsr_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          tsr_q  <= {tsr_q[6:0], 1'b0};
          nbit_q <= nbit_q + 3'd1;
          if (nbit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else if (act_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = act_q & tsr_q[7];
  assign done = done_q;
  assign rx   = rsr_q;
endmodule

// File: rtl/sio_dma_pack.sv
module sio_dma_pack #(
  parameter int AW          = 32,
  parameter int BURST_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  output logic          ready,
  output logic          dma_req,
  output logic [AW-1:0] dma_addr,
  output logic [31:0]   dma_wdata,
  output logic          dma_last,
  input  logic          dma_ack
);
  localparam int BYTES = BURST_WORDS * 4;
  localparam int BI_W  = $clog2(BYTES);
  localparam int BT_W  = $clog2(BURST_WORDS);

  function automatic logic [AW-1:0] beat_address(input logic [AW-1:0] a, input logic [BT_W-1:0] k);
    return a + AW'({k, 2'b00});
  endfunction

  function automatic logic [4:0] lane_lsb(input logic [1:0] lane);
    return 5'd24 - {lane, 3'b000};
  endfunction

  logic [31:0]     buf_q [BURST_WORDS];
  logic [BI_W-1:0] bi_q;
  logic [BT_W-1:0] beat_q;
  logic            burst_q;
  logic [AW-1:0]   addr_q;
  logic            beat_last;

  assign beat_last = (beat_q == BT_W'(BURST_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BURST_WORDS; i++) buf_q[i] <= '0;
      bi_q    <= '0;
      beat_q  <= '0;
      burst_q <= 1'b0;
      addr_q  <= '0;
    end else if (start) begin
      bi_q    <= '0;
      beat_q  <= '0;
      burst_q <= 1'b0;
      addr_q  <= base;
    end else if (burst_q) begin
      if (dma_ack) begin
        if (beat_last) begin
          burst_q <= 1'b0;
          beat_q  <= '0;
          addr_q  <= addr_q + AW'(BYTES);
        end else begin
          beat_q <= beat_q + BT_W'(1);
        end
      end
    end else if (byte_vld) begin
      buf_q[bi_q[BI_W-1:2]][lane_lsb(bi_q[1:0]) +: 8] <= byte_in;
      bi_q <= bi_q + BI_W'(1);
      if (bi_q == BI_W'(BYTES - 1)) burst_q <= 1'b1;
    end
  end

  assign ready     = !burst_q;
  assign dma_req   = burst_q;
  assign dma_addr  = beat_address(addr_q, beat_q);
  assign dma_wdata = buf_q[beat_q];
  assign dma_last  = burst_q && beat_last;
endmodule

// File: rtl/sio_chan_ctrl.sv
module sio_chan_ctrl
  import sio_pkg::*;
#(
  parameter int NDEV        = 3,
  parameter int DIV_BASE    = 4,
  parameter int RATE_W      = 2,
  parameter int LEN_W       = 16,
  parameter int BURST_WORDS = 8,
  parameter int AW          = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wen,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NDEV-1:0] cs,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            dma_req,
  output logic [AW-1:0]   dma_addr,
  output logic [31:0]     dma_wdata,
  output logic            dma_last,
  input  logic            dma_ack
);
  localparam int MAX_HALF = DIV_BASE << ((1 << RATE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  sio_st_e          st_q;
  logic [NDEV-1:0]  cs_q;
  logic [RATE_W-1:0] rate_q;
  logic             dma_q;
  logic [1:0]       dir_q;
  logic [1:0]       nlen_q;
  logic [31:0]      data_q;
  logic [AW-1:5]    addr_q;
  logic [LEN_W-1:5] len_q;
  logic [LEN_W-1:0] left_q;
  logic [1:0]       ibyte_q;

  logic             busy;
  logic             wr_ok;
  logic             start_go;
  logic             sh_go;
  logic             sh_done;
  logic [7:0]       sh_rx;
  logic [7:0]       sh_tx;
  logic [CNT_W-1:0] half;
  logic             pk_ready;
  logic             byte_to_mem;
  logic             fin_evt;

  function automatic logic [NDEV-1:0] sel_clean(input logic [NDEV-1:0] v);
    return (ones_in(8'(v)) <= 1) ? v : '0;
  endfunction

  assign busy     = (st_q != ST_IDLE);
  assign wr_ok    = reg_wen && !busy;
  assign start_go = wr_ok && (reg_addr == REG_CTRL) && reg_wdata[CTRL_START];
  assign half     = CNT_W'(half_cycles(DIV_BASE, int'(rate_q)));

  assign sh_go = (st_q == ST_NEXT) && (!dma_q || ((left_q != '0) && pk_ready));
  assign sh_tx = (dma_q || dir_q == DIR_RD) ? 8'hFF : imm_byte(data_q, ibyte_q);
  assign byte_to_mem = (st_q == ST_RUN) && sh_done && dma_q;
  assign fin_evt = ((st_q == ST_RUN) && sh_done && !dma_q && (ibyte_q == nlen_q)) ||
                   ((st_q == ST_DRAIN) && pk_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_q    <= '0;
      rate_q  <= '0;
      dma_q   <= 1'b0;
      dir_q   <= '0;
      nlen_q  <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      left_q  <= '0;
      ibyte_q <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          REG_SEL: begin
            cs_q   <= sel_clean(reg_wdata[NDEV-1:0]);
            rate_q <= reg_wdata[SEL_RATE +: RATE_W];
          end
          REG_CTRL: begin
            dma_q  <= reg_wdata[CTRL_DMA];
            dir_q  <= reg_wdata[CTRL_DIR +: 2];
            nlen_q <= reg_wdata[CTRL_LEN +: 2];
          end
          REG_DATA: data_q <= reg_wdata;
          REG_ADDR: addr_q <= reg_wdata[AW-1:5];
          REG_LEN:  len_q  <= reg_wdata[LEN_W-1:5];
          default: ;
        endcase
      end
      case (st_q)
        ST_IDLE: begin
          if (start_go) begin
            st_q    <= ST_NEXT;
            ibyte_q <= '0;
            left_q  <= {len_q, 5'b00000};
          end
        end
        ST_NEXT: begin
          if (dma_q && left_q == '0) st_q <= ST_DRAIN;
          else if (sh_go)            st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (sh_done) begin
            if (dma_q) begin
              left_q <= left_q - LEN_W'(1);
              st_q   <= ST_NEXT;
            end else begin
              if (dir_q != DIR_WR) data_q <= imm_merge(data_q, ibyte_q, sh_rx);
              if (ibyte_q == nlen_q) begin
                st_q <= ST_IDLE;
              end else begin
                ibyte_q <= ibyte_q + 2'd1;
                st_q    <= ST_NEXT;
              end
            end
          end
        end
        ST_DRAIN: if (pk_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      REG_SEL:  reg_rdata = 32'(cs_q) | (32'(rate_q) << SEL_RATE);
      REG_CTRL: reg_rdata = 32'({nlen_q, dir_q, dma_q, busy});
      REG_DATA: reg_rdata = data_q;
      REG_ADDR: reg_rdata = 32'({addr_q, 5'b00000});
      REG_LEN:  reg_rdata = 32'({len_q, 5'b00000});
      default:  reg_rdata = '0;
    endcase
  end

  sio_shift #(.CNT_W(CNT_W)) u_shift (
    .clk (clk),
    .rst_n(rst_n),
    .go  (sh_go),
    .tx  (sh_tx),
    .half(half),
    .miso(miso),
    .sclk(sclk),
    .mosi(mosi),
    .done(sh_done),
    .rx  (sh_rx)
  );

  sio_dma_pack #(.AW(AW), .BURST_WORDS(BURST_WORDS)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_go && reg_wdata[CTRL_DMA]),
    .base     ({addr_q, 5'b00000}),
    .byte_vld (byte_to_mem),
    .byte_in  (sh_rx),
    .ready    (pk_ready),
    .dma_req  (dma_req),
    .dma_addr (dma_addr),
    .dma_wdata(dma_wdata),
    .dma_last (dma_last),
    .dma_ack  (dma_ack)
  );

  assign cs = cs_q;
endmodule

// File: rtl/sio_chan_chk.sv
module sio_chan_chk #(
  parameter int NDEV = 3,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wen,
  input logic [NDEV-1:0] cs,
  input logic            sclk,
  input logic            mosi,
  input logic            dma_req,
  input logic [AW-1:0]   dma_addr,
  input logic [31:0]     dma_wdata,
  input logic            dma_last,
  input logic            dma_ack,
  input logic            busy,
  input logic            fin_evt
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fin_evt));

  assert_line_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi));

  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_addr) && $stable(dma_wdata) && $stable(dma_last)));

  assert_req_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> busy);

  assert_sel_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wen) |=> $stable(cs));
endmodule

bind sio_chan_ctrl sio_chan_chk #(.NDEV(NDEV), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wen  (reg_wen),
  .cs       (cs),
  .sclk     (sclk),
  .mosi     (mosi),
  .dma_req  (dma_req),
  .dma_addr (dma_addr),
  .dma_wdata(dma_wdata),
  .dma_last (dma_last),
  .dma_ack  (dma_ack),
  .busy     (busy),
  .fin_evt  (fin_evt)
);

// File: tb/sim_sio_chan_ctrl.sv
module sim_sio_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 3;
  localparam int AW   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NDEV-1:0] cs;
  logic sclk, mosi, miso;
  logic dma_req, dma_last;
  logic dma_ack = 1'b0;
  logic [AW-1:0] dma_addr;
  logic [31:0] dma_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_chan_ctrl #(.NDEV(NDEV), .DIV_BASE(2), .RATE_W(2), .LEN_W(16),
                  .BURST_WORDS(8), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs(cs), .sclk(sclk),
    .mosi(mosi), .miso(miso), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_last(dma_last), .dma_ack(dma_ack));

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // device model: only device 0 is present
  logic [7:0] sbase = 8'h00;
  int sidx = 0;
  int sbit = 0;
  function automatic logic [7:0] pbyte(input logic [7:0] b, input int i);
    return b + 8'(i * 19);
  endfunction
  logic [7:0] cur_b;
  assign cur_b = pbyte(sbase, sidx);
  assign miso  = cs[0] ? cur_b[7 - sbit] : 1'b1;
  always @(negedge sclk) begin
    if (sbit == 7) begin sbit = 0; sidx++; end
    else sbit++;
  end
  task automatic slave_reset(input logic [7:0] b);
    sbase = b; sidx = 0; sbit = 0;
  endtask

  // cycle count (negedge) and sclk period monitor
  int cyc = 0;
  always @(negedge clk) cyc++;
  int last_rise = 0;
  int period_seen = 0;

  // scoreboard for outgoing serial bytes
  logic [7:0] exp_mosi[$];
  string      exp_tag[$];
  logic [7:0] mbits = 8'h00;
  int mcnt = 0;
  always @(posedge sclk) begin
    if (mcnt != 0) period_seen = cyc - last_rise;
    last_rise = cyc;
    mbits = {mbits[6:0], mosi};
    mcnt++;
    if (mcnt == 8) begin
      mcnt = 0;
      if (exp_mosi.size() == 0) chk("R4 unexpected serial byte", 32'(mbits), 32'hxx);
      else chk(exp_tag.pop_front(), 32'(mbits), 32'(exp_mosi.pop_front()));
    end
  end

  // scoreboard for DMA beats; ack on alternate cycles
  logic [31:0] exp_ba[$];
  logic [31:0] exp_bd[$];
  logic        exp_bl[$];
  int beats = 0;
  logic ack_ph = 1'b0;
  always @(negedge clk) begin
    ack_ph = ~ack_ph;
    dma_ack = dma_req && ack_ph;
    if (dma_ack) begin
      beats++;
      if (exp_ba.size() == 0) chk("R8 unexpected beat", dma_addr, 32'hx);
      else begin
        chk("R8 beat address", dma_addr, exp_ba.pop_front());
        chk("R8 beat data", dma_wdata, exp_bd.pop_front());
        chk("R8 beat last", 32'(dma_last), 32'(exp_bl.pop_front()));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'h1;
    while (v[0] && n < 5000) begin rd(3'd1, v); n++; end
    chk(tag, 32'(v[0]), 32'h0);
  endtask

  task automatic push_out(input string tag, input logic [1:0] dir, input int nb,
                          input logic [31:0] d);
    for (int i = 0; i < nb; i++) begin
      exp_mosi.push_back(dir == 2'd0 ? 8'hFF : d[31 - 8*i -: 8]);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic imm(input logic [1:0] dir, input int nb);
    wr(3'd1, 32'h1 | (32'(dir) << 2) | (32'(nb - 1) << 4));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 cs reset", 32'(cs), 32'h0);
    chk("R1 sclk/mosi idle", {30'h0, sclk, mosi}, 32'h0);
    chk("R1 no request", 32'(dma_req), 32'h0);

    // R2 select device 0, rate 0
    wr(3'd0, 32'h001);
    chk("R2 cs follows select", 32'(cs), 32'h1);

    // R4 write 2 bytes; R3 busy; R9 locked writes
    wr(3'd2, 32'hA55A1234);
    push_out("R4 write mosi byte", 2'd1, 2, 32'hA55A1234);
    imm(2'd1, 2);
    rd(3'd1, v);
    chk("R3 start reads one while busy", 32'(v[0]), 32'h1);
    wr(3'd2, 32'hDEADBEEF);
    wr(3'd0, 32'h004);
    chk("R9 select write ignored while busy", 32'(cs), 32'h1);
    wait_idle("R3 start clears");
    rd(3'd2, v);
    chk("R4 R9 data unchanged after write", v, 32'hA55A1234);
    chk("R7 period at rate 0", 32'(period_seen), 32'd4);
    rd(3'd0, v);
    chk("R9 select register kept", v, 32'h001);

    // R5 read 1 byte, lower bytes kept
    wr(3'd2, 32'h00112233);
    slave_reset(8'h3C);
    push_out("R5 read mosi byte", 2'd0, 1, 32'h0);
    imm(2'd0, 1);
    wait_idle("R3 start clears after read");
    rd(3'd2, v);
    chk("R5 one-byte read left aligned", v, 32'h3C112233);
    chk("R2 cs held across transfers", 32'(cs), 32'h1);

    // R5 four-byte read at rate 2, R7 period
    wr(3'd0, 32'h201);
    slave_reset(8'h50);
    push_out("R5 read mosi byte", 2'd0, 4, 32'h0);
    imm(2'd0, 4);
    wait_idle("R3 start clears after long read");
    rd(3'd2, v);
    chk("R5 four-byte read", v, {pbyte(8'h50,0), pbyte(8'h50,1), pbyte(8'h50,2), pbyte(8'h50,3)});
    chk("R7 period at rate 2", 32'(period_seen), 32'd16);

    // R6 full duplex
    wr(3'd0, 32'h001);
    wr(3'd2, 32'hC3A50F96);
    slave_reset(8'h01);
    push_out("R6 duplex mosi byte", 2'd2, 4, 32'hC3A50F96);
    imm(2'd2, 4);
    wait_idle("R3 start clears after duplex");
    rd(3'd2, v);
    chk("R6 duplex data replaced", v, {pbyte(8'h01,0), pbyte(8'h01,1), pbyte(8'h01,2), pbyte(8'h01,3)});

    // R5 identification of an absent device
    wr(3'd0, 32'h002);
    chk("R2 cs device 1", 32'(cs), 32'h2);
    wr(3'd2, 32'h0);
    push_out("R5 id command byte", 2'd1, 2, 32'h0);
    imm(2'd1, 2);
    wait_idle("R3 id command done");
    push_out("R5 id read mosi byte", 2'd0, 4, 32'h0);
    imm(2'd0, 4);
    wait_idle("R3 id read done");
    rd(3'd2, v);
    chk("R5 absent device reads ones", v, 32'hFFFFFFFF);

    // R2 deselect and multi-bit select
    wr(3'd0, 32'h000);
    chk("R2 zero deselects", 32'(cs), 32'h0);
    wr(3'd0, 32'h003);
    chk("R2 multi-bit deselects", 32'(cs), 32'h0);

    // R10 address/length low bits, R8 DMA of 64 bytes
    wr(3'd0, 32'h001);
    wr(3'd3, 32'h00001234);
    rd(3'd3, v);
    chk("R10 address low bits zero", v, 32'h00001220);
    wr(3'd4, 32'h47);
    rd(3'd4, v);
    chk("R10 length low bits zero", v, 32'h40);
    slave_reset(8'h20);
    push_out("R8 dma mosi byte", 2'd0, 64, 32'h0);
    for (int k = 0; k < 16; k++) begin
      w = {pbyte(8'h20,4*k), pbyte(8'h20,4*k+1), pbyte(8'h20,4*k+2), pbyte(8'h20,4*k+3)};
      exp_ba.push_back(32'h1220 + 32'(4*k));
      exp_bd.push_back(w);
      exp_bl.push_back((k % 8) == 7);
    end
    beats = 0;
    wr(3'd1, 32'h3);
    wait_idle("R8 dma start clears");
    chk("R8 all beats before start clears", 32'(beats), 32'd16);
    chk("R8 serial queue drained", 32'(exp_mosi.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule